// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block watches the signed samples of a voltage channel and reduces each line cycle to one number: the largest sample magnitude seen between two line-cycle boundary strobes. At every boundary that closing peak is compared with a programmable 8-bit sag level. If the peak is below the level, the cycle counts as low. A run of consecutive low cycles is counted. When the run reaches a programmable cycle count, an active-low sag pin goes low.

The pin stays low until a cycle closes with a peak at or above the level. Each time the pin asserts, a sticky status bit is set. That bit stays set until it is cleared explicitly. The cycle count and the level are loaded through simple write strobes. Zero-cross generation, filtering and the host bus are handled by neighbouring logic, which supplies the boundary strobe and the write strobes.

Top module: `sag_detect`

## Requirements
- R1: After reset, sagN is 1 and sagSticky is 0. The cycle-count register holds 0xFF and the level register holds 0. With only the level written, the pin asserts at the end of the 255th consecutive low cycle and not before.
- R2: A sample's magnitude is its absolute value, saturated to 0x7FFF, so -32768 gives 0x7FFF. It is compared through bits [14:7] of that 15-bit magnitude. For example, -0x0800 gives 0x10 and -0x07FF gives 0x0F.
- R3: The closing peak of a cycle is the maximum compared magnitude over all valid samples of that cycle. A cycle is low when that peak is strictly below the level.
- R4: A sample that is valid in the same clock as the boundary strobe belongs to the cycle that closes. The peak then restarts at zero, so a cycle with no valid samples has a peak of 0.
- R5: Each low cycle increments a consecutive-cycle counter. sagN goes low on the boundary edge where the counter reaches the cycle-count register. sagN changes only on boundary strobes.
- R6: A cycle that is not low clears the counter and releases sagN (drives it to 1) on that boundary edge.
- R7: sagSticky is set on the edge where sagN asserts. It is cleared by statusClr, and a set in the same clock as statusClr wins.
- R8: The counter saturates at 255 without wrapping, so an asserted sag with a count of 0xFF stays asserted. A cycle count of 0 never asserts the pin.
- R9: A level of 0 makes no cycle low, so a cycle with peak 0 does not assert sag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Sample strobe |
| sampleIn | input | 16 | Signed voltage sample |
| cycleStrobe | input | 1 | Line-cycle boundary strobe |
| cycWrEn | input | 1 | Write strobe for the cycle-count register |
| cycWrData | input | 8 | Cycle-count write data |
| lvlWrEn | input | 1 | Write strobe for the level register |
| lvlWrData | input | 8 | Level write data |
| statusClr | input | 1 | Clears the sticky status bit |
| sagN | output | 1 | Sag pin, active low |
| sagSticky | output | 1 | Sticky sag status |

## Verification
Two pairs of events can fall in the same clock. The first pair is a valid sample and the boundary strobe. The bench provokes it by driving a large sample only in the strobe clock, and expects that sample to keep its own cycle from counting as low. It then closes the following cycle with no samples and expects that cycle to count as low, which shows the peak restarted at zero. The second pair is a sag assertion and a status clear: statusClr is driven in the strobe clock that completes the run, and the sticky bit must read 1 afterwards.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // strobes issued by the control to the datapath at a line-cycle boundary
  typedef struct packed {
    logic peakRestart;
    logic runInc;
    logic runClr;
  } sagStrobe_t;
endpackage

// File: rtl/sag_datapath.sv
module sag_datapath
  import sag_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LVL_W    = 8,
  parameter int CNT_W    = 8,
  parameter logic [CNT_W-1:0] CYC_RST = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                cycWrEn,
  input  logic [CNT_W-1:0]    cycWrData,
  input  logic                lvlWrEn,
  input  logic [LVL_W-1:0]    lvlWrData,
  input  sagStrobe_t          strobes,
  output logic                closingLow,
  output logic                runHit
);
  localparam int MAG_W = SAMPLE_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [MAG_W-1:0] mag;
  logic [LVL_W-1:0] sampleTop;
  logic [LVL_W-1:0] peakReg, closingPeak;
  logic [LVL_W-1:0] lvlReg;
  logic [CNT_W-1:0] cycReg, runCnt;
  logic [CNT_W:0]   runNext;

  // saturating absolute value
  always_comb begin
    if (sampleIn[SAMPLE_W-1]) begin
      if (sampleIn[MAG_W-1:0] == '0) mag = '1;
      else                           mag = MAG_W'(~sampleIn[MAG_W-1:0] + 1'b1);
    end else begin
      mag = sampleIn[MAG_W-1:0];
    end
  end

  assign sampleTop   = mag[MAG_W-1 -: LVL_W];
  assign closingPeak = (sampleValid && sampleTop > peakReg) ? sampleTop : peakReg;
  assign closingLow  = closingPeak < lvlReg;
  assign runNext     = {1'b0, runCnt} + 1'b1;
  assign runHit      = runNext == {1'b0, cycReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlReg <= '0;
      cycReg <= CYC_RST;
    end else begin
      if (lvlWrEn) lvlReg <= lvlWrData;
      if (cycWrEn) cycReg <= cycWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    peakReg <= '0;
    else if (strobes.peakRestart) peakReg <= '0;
    else                          peakReg <= closingPeak;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               runCnt <= '0;
    else if (strobes.runClr) runCnt <= '0;
    else if (strobes.runInc && runCnt != CNT_MAX) runCnt <= runNext[CNT_W-1:0];
  end

  AST_PEAK_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobes.peakRestart |=> peakReg == '0); // R4
  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.peakRestart |=> peakReg >= $past(peakReg)); // R3
  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runClr |=> runCnt == '0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.runInc && runCnt == CNT_MAX) |=> runCnt == CNT_MAX); // R8
endmodule

// File: rtl/sag_control.sv
module sag_control
  import sag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStrobe,
  input  logic       closingLow,
  input  logic       runHit,
  input  logic       statusClr,
  output sagStrobe_t strobes,
  output logic       sagActive,
  output logic       sagSticky
);
  logic sagSet;

  always_comb begin
    strobes.peakRestart = cycleStrobe;
    strobes.runInc      = cycleStrobe && closingLow;
    strobes.runClr      = cycleStrobe && !closingLow;
  end

  assign sagSet = strobes.runInc && runHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sagActive <= 1'b0;
    else if (strobes.runClr) sagActive <= 1'b0;
    else if (sagSet)         sagActive <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sagSticky <= 1'b0;
    else if (sagSet)    sagSticky <= 1'b1;
    else if (statusClr) sagSticky <= 1'b0;
  end

  AST_SAG_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runClr |=> !sagActive); // R6
  AST_SAG_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStrobe |=> $stable(sagActive)); // R5
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sagActive) |-> sagSticky); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.runInc && strobes.runClr)); // R5
endmodule

// File: rtl/sag_detect.sv
module sag_detect
  import sag_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LVL_W    = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                cycleStrobe,
  input  logic                cycWrEn,
  input  logic [CNT_W-1:0]    cycWrData,
  input  logic                lvlWrEn,
  input  logic [LVL_W-1:0]    lvlWrData,
  input  logic                statusClr,
  output logic                sagN,
  output logic                sagSticky
);
  sagStrobe_t strobes;
  logic closingLow, runHit, sagActive;

  sag_datapath #(.SAMPLE_W(SAMPLE_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .cycWrEn(cycWrEn), .cycWrData(cycWrData), .lvlWrEn(lvlWrEn),
    .lvlWrData(lvlWrData), .strobes(strobes), .closingLow(closingLow),
    .runHit(runHit)
  );

  sag_control uCtl (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .closingLow(closingLow),
    .runHit(runHit), .statusClr(statusClr), .strobes(strobes),
    .sagActive(sagActive), .sagSticky(sagSticky)
  );

  assign sagN = !sagActive;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (sagN && !sagSticky)); // R1
endmodule

// File: tb/sim_sag_detect.sv
module sim_sag_detect;
  logic clk = 0;
  logic rstN = 0;
  logic sampleValid = 0;
  logic [15:0] sampleIn = '0;
  logic cycleStrobe = 0;
  logic cycWrEn = 0;
  logic [7:0] cycWrData = '0;
  logic lvlWrEn = 0;
  logic [7:0] lvlWrData = '0;
  logic statusClr = 0;
  logic sagN, sagSticky;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sag_detect u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .cycleStrobe(cycleStrobe), .cycWrEn(cycWrEn), .cycWrData(cycWrData),
    .lvlWrEn(lvlWrEn), .lvlWrData(lvlWrData), .statusClr(statusClr),
    .sagN(sagN), .sagSticky(sagSticky)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrCyc(input logic [7:0] v);
    @(negedge clk); cycWrEn = 1; cycWrData = v;
    @(negedge clk); cycWrEn = 0;
  endtask

  task automatic wrLvl(input logic [7:0] v);
    @(negedge clk); lvlWrEn = 1; lvlWrData = v;
    @(negedge clk); lvlWrEn = 0;
  endtask

  task automatic feed(input logic [15:0] s);
    @(negedge clk); sampleValid = 1; sampleIn = s;
    @(negedge clk); sampleValid = 0;
  endtask

  // close the cycle, optionally with a sample in the strobe clock
  task automatic closeCycle(input bit withSample, input logic [15:0] s);
    @(negedge clk); cycleStrobe = 1; sampleValid = withSample; sampleIn = s;
    @(negedge clk); cycleStrobe = 0; sampleValid = 0;
  endtask

  task automatic lowCycle();
    feed(16'h0100); closeCycle(0, '0);
  endtask

  task automatic highCycle();
    feed(16'h7FFF); closeCycle(0, '0);
  endtask

  task automatic t_reset();
    chk("R1 sagN after reset", sagN, 1);
    chk("R1 sticky after reset", sagSticky, 0);
  endtask

  task automatic t_defaultCount();
    wrLvl(8'h40);
    for (int i = 0; i < 254; i++) lowCycle();
    chk("R1 no sag before 255 cycles", sagN, 1);
    lowCycle();
    chk("R1 R5 sag at 255th cycle", sagN, 0);
    chk("R7 sticky set on sag", sagSticky, 1);
    for (int i = 0; i < 3; i++) lowCycle();
    chk("R8 saturated count holds sag", sagN, 0);
    highCycle();
    chk("R6 high cycle releases sag", sagN, 1);
    chk("R7 sticky held", sagSticky, 1);
  endtask

  task automatic t_magnitude();
    wrCyc(8'd1); wrLvl(8'h10);
    feed(16'hF800); closeCycle(0, '0);
    chk("R2 -0x0800 is 0x10 not low", sagN, 1);
    feed(16'hF801); closeCycle(0, '0);
    chk("R2 -0x07FF is 0x0F low", sagN, 0);
    feed(16'h8000); closeCycle(0, '0);
    chk("R2 most negative saturates not low", sagN, 1);
    feed(16'h07FF); closeCycle(0, '0);
    chk("R2 0x07FF low", sagN, 0);
    highCycle();
  endtask

  task automatic t_peakMax();
    feed(16'h0100); feed(16'h0900); feed(16'h0200); closeCycle(0, '0);
    chk("R3 peak is max of cycle", sagN, 1);
    feed(16'h0100); feed(16'h0780); feed(16'h0200); closeCycle(0, '0);
    chk("R3 all below level low", sagN, 0);
    highCycle();
  endtask

  task automatic t_boundary();
    closeCycle(1, 16'h4000);
    chk("R4 strobe-clock sample in closing cycle", sagN, 1);
    closeCycle(0, '0);
    chk("R4 peak restarted at zero", sagN, 0);
    highCycle();
  endtask

  task automatic t_consecutive();
    wrCyc(8'd3);
    lowCycle(); lowCycle();
    chk("R5 two of three", sagN, 1);
    highCycle();
    lowCycle(); lowCycle();
    chk("R6 run restarted", sagN, 1);
    lowCycle();
    chk("R5 third consecutive asserts", sagN, 0);
    feed(16'h7FFF);
    chk("R5 no change between strobes", sagN, 0);
    closeCycle(0, '0);
    chk("R6 high peak releases", sagN, 1);
  endtask

  task automatic t_sticky();
    @(negedge clk); statusClr = 1;
    @(negedge clk); statusClr = 0;
    chk("R7 clear works", sagSticky, 0);
    wrCyc(8'd1);
    feed(16'h0100);
    @(negedge clk); cycleStrobe = 1; statusClr = 1;
    @(negedge clk); cycleStrobe = 0; statusClr = 0;
    chk("R7 sag asserted", sagN, 0);
    chk("R7 set wins over clear", sagSticky, 1);
    highCycle();
  endtask

  task automatic t_zeroCount();
    wrCyc(8'd0);
    for (int i = 0; i < 5; i++) lowCycle();
    chk("R8 count zero never asserts", sagN, 1);
  endtask

  task automatic t_levelZero();
    wrCyc(8'd1); wrLvl(8'h00);
    closeCycle(0, '0);
    chk("R9 level zero never low", sagN, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_defaultCount();
    t_magnitude();
    t_peakMax();
    t_boundary();
    t_consecutive();
    t_sticky();
    t_zeroCount();
    t_levelZero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule